// File: doc/BRIEF.md
# General-purpose register bank with index-31 aliasing

This block is the integer register bank of a 64-bit load/store core. Index values 0 to 30 select 64-bit storage registers. Index 31 selects no storage. Each access carries a one-bit context that decides what index 31 means:
- Context 0 makes index 31 a constant zero. Reads return zero and writes to it are dropped.
- Context 1 makes index 31 name a dedicated stack pointer register.

There are two combinational read ports, A and B, and one clocked write port. Any read can be narrowed to the low half of the word. A narrow write stores the low half and clears the upper half. A separate branch-with-link port loads the return address into register 30, which otherwise behaves as an ordinary register.

Port A also serves as the base-address port. When it is marked valid and names the stack pointer, the block raises a combinational fault if the stack pointer is not 16-byte aligned. The reset is asynchronous and active low.

Top module: `gpr_bank`

## Requirements
- R1: While `rst_ni` is low, all 31 storage registers and the stack pointer are cleared to zero. After reset, every read returns zero.
- R2: A full-width write with `wr_en_i`=1 and index 0..30 takes effect at the rising clock edge. After that edge, both read ports return the written value at that index.
- R3: Index 31 with context 0 reads as zero on either port. A write to index 31 with context 0 leaves the stack pointer and every storage register unchanged.
- R4: Index 31 with context 1 reads the stack pointer on either port. A write to index 31 with context 1 loads the stack pointer.
- R5: A write with the narrow flag set stores `wr_data_i[31:0]` in bits 31:0 and forces bits 63:32 to zero. This also applies to the stack pointer.
- R6: A read with the narrow flag set returns bits 31:0 of the selected value, with bits 63:32 of the output equal to zero.
- R7: A read of an index that is being written in the same cycle returns the value held before the clock edge.
- R8: `lnk_en_i` loads `lnk_addr_i` into register 30 at the clock edge. If the general port writes register 30 in the same cycle, the link value is the one stored. A general write to any other index in the same cycle still takes effect.
- R9: `align_fault_o` is 1 exactly when all of the following hold: `base_vld_i`=1, `ra_idx_i`=31, `ra_sp_i`=1, and stack pointer bits 3:0 are nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | General write enable |
| wr_idx_i | input | 5 | Write index |
| wr_sp_i | input | 1 | Write context for index 31 (1 = stack pointer) |
| wr_narrow_i | input | 1 | 32-bit write with zero extension |
| wr_data_i | input | 64 | Write data |
| lnk_en_i | input | 1 | Link write enable for register 30 |
| lnk_addr_i | input | 64 | Return address |
| ra_idx_i | input | 5 | Port A index |
| ra_sp_i | input | 1 | Port A context for index 31 |
| ra_narrow_i | input | 1 | Port A 32-bit read |
| ra_data_o | output | 64 | Port A data |
| rb_idx_i | input | 5 | Port B index |
| rb_sp_i | input | 1 | Port B context for index 31 |
| rb_narrow_i | input | 1 | Port B 32-bit read |
| rb_data_o | output | 64 | Port B data |
| base_vld_i | input | 1 | Port A is used as a base address this cycle |
| align_fault_o | output | 1 | Stack pointer misaligned as base |

## Verification
The bench builds the block with its defaults: 64-bit data, 31 storage registers, 16-byte alignment and link register 30.

At those values every bit of the 5-bit index is meaningful. This puts the boundary between register 30 and the alias at 31 within reach. It also makes the zero-extension boundary at bit 32 visible in both write and read data.

The alignment checks use stack pointer values on both sides of a 16-byte multiple, so that each of the low four bits can raise the fault.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
  typedef enum logic {CTX_ZERO = 1'b0, CTX_SP = 1'b1} alias_ctx_e;
endpackage

// File: rtl/gpr_rd_port.sv
module gpr_rd_port #(
  parameter int XLEN  = 64,
  parameter int NREGS = 31,
  localparam int IDXW = $clog2(NREGS + 1),
  localparam int HALF = XLEN / 2
) (
  input  logic [XLEN-1:0] regs_i [NREGS],
  input  logic [XLEN-1:0] sp_i,
  input  logic [IDXW-1:0] idx_i,
  input  logic            sp_sel_i,
  input  logic            narrow_i,
  output logic [XLEN-1:0] data_o
);
  import gpr_pkg::*;
  logic [XLEN-1:0] raw;

  always_comb begin
    if (idx_i >= IDXW'(NREGS))
      raw = (alias_ctx_e'(sp_sel_i) == CTX_SP) ? sp_i : '0;
    else
      raw = regs_i[idx_i];
    data_o = narrow_i ? {{(XLEN-HALF){1'b0}}, raw[HALF-1:0]} : raw;
  end
endmodule

// File: rtl/gpr_store.sv
module gpr_store #(
  parameter int XLEN     = 64,
  parameter int NREGS    = 31,
  parameter int LINK_IDX = 30,
  localparam int IDXW = $clog2(NREGS + 1),
  localparam int HALF = XLEN / 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [IDXW-1:0] wr_idx_i,
  input  logic            wr_sp_i,
  input  logic            wr_narrow_i,
  input  logic [XLEN-1:0] wr_data_i,
  input  logic            lnk_en_i,
  input  logic [XLEN-1:0] lnk_addr_i,
  output logic [XLEN-1:0] regs_o [NREGS],
  output logic [XLEN-1:0] sp_o
);
  import gpr_pkg::*;
  logic [XLEN-1:0] wdata;
  logic            sp_we;

  assign wdata = wr_narrow_i ? {{(XLEN-HALF){1'b0}}, wr_data_i[HALF-1:0]} : wr_data_i;
  assign sp_we = wr_en_i && (wr_idx_i == IDXW'(NREGS)) && (alias_ctx_e'(wr_sp_i) == CTX_SP);

  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   regs_o[i] <= '0;
      else if (lnk_en_i && i == LINK_IDX)            regs_o[i] <= lnk_addr_i; // link has priority
      else if (wr_en_i && wr_idx_i == IDXW'(i))      regs_o[i] <= wdata;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sp_o <= '0;
    else if (sp_we) sp_o <= wdata;
  end

  // R3: zero-context write to index 31 must not move the stack pointer
  assert_zero_wr_drop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_idx_i == IDXW'(NREGS) && !wr_sp_i) |=> $stable(sp_o));

  assert_sp_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_idx_i == IDXW'(NREGS) && wr_sp_i && !wr_narrow_i) |=> sp_o == $past(wr_data_i));

  assert_narrow_upper_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_narrow_i && wr_idx_i < IDXW'(NREGS) && !(lnk_en_i && wr_idx_i == IDXW'(LINK_IDX)))
      |=> regs_o[$past(wr_idx_i)][XLEN-1:HALF] == '0);

  assert_link_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lnk_en_i |=> regs_o[LINK_IDX] == $past(lnk_addr_i));
endmodule

// File: rtl/gpr_bank.sv
module gpr_bank #(
  parameter int XLEN        = 64,
  parameter int NREGS       = 31,
  parameter int LINK_IDX    = 30,
  parameter int ALIGN_BYTES = 16,
  localparam int IDXW  = $clog2(NREGS + 1),
  localparam int ALIGN_W = $clog2(ALIGN_BYTES)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [IDXW-1:0] wr_idx_i,
  input  logic            wr_sp_i,
  input  logic            wr_narrow_i,
  input  logic [XLEN-1:0] wr_data_i,
  input  logic            lnk_en_i,
  input  logic [XLEN-1:0] lnk_addr_i,
  input  logic [IDXW-1:0] ra_idx_i,
  input  logic            ra_sp_i,
  input  logic            ra_narrow_i,
  output logic [XLEN-1:0] ra_data_o,
  input  logic [IDXW-1:0] rb_idx_i,
  input  logic            rb_sp_i,
  input  logic            rb_narrow_i,
  output logic [XLEN-1:0] rb_data_o,
  input  logic            base_vld_i,
  output logic            align_fault_o
);
  logic [XLEN-1:0] regs [NREGS];
  logic [XLEN-1:0] sp;

  gpr_store #(.XLEN(XLEN), .NREGS(NREGS), .LINK_IDX(LINK_IDX)) u_store (
    .clk_i, .rst_ni, .wr_en_i, .wr_idx_i, .wr_sp_i, .wr_narrow_i, .wr_data_i,
    .lnk_en_i, .lnk_addr_i, .regs_o(regs), .sp_o(sp)
  );

  gpr_rd_port #(.XLEN(XLEN), .NREGS(NREGS)) u_rd_a (
    .regs_i(regs), .sp_i(sp), .idx_i(ra_idx_i), .sp_sel_i(ra_sp_i),
    .narrow_i(ra_narrow_i), .data_o(ra_data_o)
  );

  gpr_rd_port #(.XLEN(XLEN), .NREGS(NREGS)) u_rd_b (
    .regs_i(regs), .sp_i(sp), .idx_i(rb_idx_i), .sp_sel_i(rb_sp_i),
    .narrow_i(rb_narrow_i), .data_o(rb_data_o)
  );

  assign align_fault_o = base_vld_i && ra_sp_i && (ra_idx_i == IDXW'(NREGS)) && (|sp[ALIGN_W-1:0]);

  assert_fault_qual_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    align_fault_o |-> (base_vld_i && ra_sp_i));

  assert_zero_read_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rb_idx_i == IDXW'(NREGS) && !rb_sp_i) |-> rb_data_o == '0);
endmodule

// File: tb/gpr_bank_test.sv
module gpr_bank_test;
  localparam int PERIOD = 10;

  logic        clk_i = 0, rst_ni = 0;
  logic        wr_en_i = 0, wr_sp_i = 0, wr_narrow_i = 0, lnk_en_i = 0;
  logic [4:0]  wr_idx_i = 0, ra_idx_i = 0, rb_idx_i = 0;
  logic [63:0] wr_data_i = 0, lnk_addr_i = 0;
  logic        ra_sp_i = 0, ra_narrow_i = 0, rb_sp_i = 0, rb_narrow_i = 0, base_vld_i = 0;
  logic [63:0] ra_data_o, rb_data_o;
  logic        align_fault_o;
  int total = 0, bad = 0;

  gpr_bank uut (.*);

  always #(PERIOD/2) clk_i = ~clk_i;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] idx, logic sp, logic nar, logic [63:0] d);
    @(negedge clk_i);
    wr_en_i = 1; wr_idx_i = idx; wr_sp_i = sp; wr_narrow_i = nar; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 0; wr_narrow_i = 0;
  endtask

  task automatic rd_a(logic [4:0] idx, logic sp, logic nar, output logic [63:0] d);
    ra_idx_i = idx; ra_sp_i = sp; ra_narrow_i = nar; #1; d = ra_data_o;
  endtask

  task automatic rd_b(logic [4:0] idx, logic sp, logic nar, output logic [63:0] d);
    rb_idx_i = idx; rb_sp_i = sp; rb_narrow_i = nar; #1; d = rb_data_o;
  endtask

  task automatic t_reset();
    logic [63:0] d;
    rd_a(5'd5, 0, 0, d);  check("R1 r5", d, 0);
    rd_b(5'd30, 0, 0, d); check("R1 r30", d, 0);
    rd_a(5'd31, 1, 0, d); check("R1 sp", d, 0);
  endtask

  task automatic t_full();
    logic [63:0] d;
    wr(5'd3, 0, 0, 64'h0123_4567_89AB_CDEF);
    rd_a(5'd3, 0, 0, d); check("R2 portA", d, 64'h0123_4567_89AB_CDEF);
    rd_b(5'd3, 0, 0, d); check("R2 portB", d, 64'h0123_4567_89AB_CDEF);
    wr(5'd0, 0, 0, 64'hFFFF_0000_FFFF_0001);
    rd_b(5'd0, 0, 0, d); check("R2 r0", d, 64'hFFFF_0000_FFFF_0001);
  endtask

  task automatic t_sp();
    logic [63:0] d;
    wr(5'd31, 1, 0, 64'h1000_0000_0000_0040);
    rd_b(5'd31, 1, 0, d); check("R4 portB sp", d, 64'h1000_0000_0000_0040);
    rd_a(5'd31, 1, 0, d); check("R4 portA sp", d, 64'h1000_0000_0000_0040);
    rd_a(5'd31, 0, 0, d); check("R3 zero A", d, 0);
  endtask

  task automatic t_zero();
    logic [63:0] d;
    wr(5'd31, 0, 0, 64'hDEAD_DEAD_DEAD_DEAD);
    rd_b(5'd31, 0, 0, d); check("R3 zero B", d, 0);
    rd_a(5'd31, 1, 0, d); check("R3 sp unchanged", d, 64'h1000_0000_0000_0040);
    rd_a(5'd30, 0, 0, d); check("R3 r30 unchanged", d, 0);
    rd_b(5'd3, 0, 0, d);  check("R3 r3 unchanged", d, 64'h0123_4567_89AB_CDEF);
  endtask

  task automatic t_narrow();
    logic [63:0] d;
    wr(5'd7, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF);
    wr(5'd7, 0, 1, 64'hDEAD_BEEF_1234_5678);
    rd_a(5'd7, 0, 0, d); check("R5 narrow wr", d, 64'h0000_0000_1234_5678);
    rd_a(5'd3, 0, 1, d); check("R6 narrow rd A", d, 64'h0000_0000_89AB_CDEF);
    rd_b(5'd31, 1, 1, d); check("R6 narrow rd sp", d, 64'h0000_0000_0000_0040);
  endtask

  task automatic t_same_cycle();
    logic [63:0] d;
    wr(5'd9, 0, 0, 64'h1);
    @(negedge clk_i);
    wr_en_i = 1; wr_idx_i = 5'd9; wr_sp_i = 0; wr_data_i = 64'h2;
    rd_a(5'd9, 0, 0, d); check("R7 old value", d, 64'h1);
    @(negedge clk_i); wr_en_i = 0;
    rd_a(5'd9, 0, 0, d); check("R7 new value", d, 64'h2);
  endtask

  task automatic t_link();
    logic [63:0] d;
    @(negedge clk_i);
    lnk_en_i = 1; lnk_addr_i = 64'h4000;
    wr_en_i = 1; wr_idx_i = 5'd30; wr_sp_i = 0; wr_data_i = 64'h5;
    @(negedge clk_i);
    lnk_en_i = 0; wr_en_i = 0;
    rd_a(5'd30, 0, 0, d); check("R8 link wins", d, 64'h4000);
    @(negedge clk_i);
    lnk_en_i = 1; lnk_addr_i = 64'h8008;
    wr_en_i = 1; wr_idx_i = 5'd4; wr_data_i = 64'h44;
    @(negedge clk_i);
    lnk_en_i = 0; wr_en_i = 0;
    rd_a(5'd30, 0, 0, d); check("R8 link r30", d, 64'h8008);
    rd_b(5'd4, 0, 0, d);  check("R8 parallel r4", d, 64'h44);
  endtask

  task automatic t_fault();
    logic [63:0] d;
    base_vld_i = 1;
    rd_a(5'd31, 1, 0, d); check("R9 aligned", {63'b0, align_fault_o}, 0);
    for (int b = 0; b < 4; b++) begin
      wr(5'd31, 1, 0, 64'h40 | (64'h1 << b));
      rd_a(5'd31, 1, 0, d); check("R9 misaligned", {63'b0, align_fault_o}, 1);
    end
    rd_a(5'd31, 0, 0, d); check("R9 zero ctx", {63'b0, align_fault_o}, 0);
    rd_a(5'd5, 1, 0, d);  check("R9 other idx", {63'b0, align_fault_o}, 0);
    base_vld_i = 0;
    rd_a(5'd31, 1, 0, d); check("R9 not valid", {63'b0, align_fault_o}, 0);
  endtask

  initial begin
    #(PERIOD * 3);
    t_reset();
    @(negedge clk_i); rst_ni = 1;
    t_reset();
    t_full();
    t_sp();
    t_zero();
    t_narrow();
    t_same_cycle();
    t_link();
    t_fault();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(PERIOD * 5000);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule